// File: doc/BRIEF.md
# Virtqueue Descriptor Chain Walker

This block takes the next pending request from a split-ring virtqueue in system memory. It works out where the descriptor table, the available ring and the used ring sit from a page number and a queue size. On a fetch command it reads the head index from the available ring. It then follows the linked descriptors and sorts each buffer into a device-writable ("in") list or a device-readable ("out") list. Each segment is reported as one record. The block also keeps the next-available index.

A controller issues one command at a time: a fetch that consumes the entry, a fetch that only peeks, or a skip. Memory is reached through a single-outstanding read port. Each read returns eight bytes, little-endian, starting at the requested byte address. The response may come back in the same cycle as the request or any number of cycles later. Payload data, the used ring and interrupts belong to other blocks.

Top module: `vq_chain_walker`

## Requirements
- R1: `desc_base` equals `cfg_pfn` shifted left by PAGE_SHIFT (default 12), and `avail_base` equals `desc_base + 16 * 2^cfg_qlog2`.
- R2: `used_base` equals `avail_base + 4 + 2 * 2^cfg_qlog2`, rounded up to the next multiple of 2^PAGE_SHIFT.
- R3: When `next_avail` equals `drv_avail_idx`, a fetch or a skip finishes with `done_empty`=1. It issues no memory read, emits no segment and leaves `next_avail` unchanged.
- R4: A fetch first reads the head at `avail_base + 4 + 2*(next_avail mod size)` and takes the head from bits 15:0. For each descriptor index i it then reads `desc_base + 16*(i mod size)`, giving the buffer address, and then that address +8, giving the length in bits 31:0, the flags in bits 47:32 and the next index in bits 63:48.
- R5: A fetch with `cmd_remove`=1 raises `next_avail` by one, wrapping at 16 bits. With `cmd_remove`=0 the index is left unchanged, so the same entry is fetched again.
- R6: A skip on a non-empty queue raises `next_avail` by one, issues no memory read and finishes with `done_empty`=0.
- R7: A descriptor whose flags bit 1 (device-writes) is set is reported with `seg_in`=1; otherwise `seg_in`=0. Segments come out in chain order, and `seg_pos` counts from 0 separately in each list.
- R8: While flags bit 0 (chained) is set, the walk continues at the next-index field modulo size. A descriptor with bit 0 clear ends the fetch with `done_err`=0.
- R9: If a chain holds more than MAX_SEGS (default 8) descriptors, exactly MAX_SEGS segments are emitted. The fetch then ends with `done_err`=1 and no further read.
- R10: At the end of a fetch, `done_head` is the raw head index read from the ring, and `done_n_in`/`done_n_out` are the segment counts of that fetch alone.
- R11: `cmd_ready` is high only while idle. A command presented while busy is ignored, and each accepted command gives exactly one `done_valid` pulse.
- R12: After reset `next_avail` is 0, `cmd_ready` is 1, and `mem_req`, `seg_valid` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pfn | input | PFN_W | Page number of the descriptor table |
| cfg_qlog2 | input | 4 | log2 of the queue size |
| drv_avail_idx | input | 16 | Available index published by the driver |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_skip | input | 1 | 1 = skip, 0 = fetch |
| cmd_remove | input | 1 | Fetch consumes the entry (1) or peeks (0) |
| cmd_ready | output | 1 | Idle, a command may be given |
| next_avail | output | 16 | Next-available index |
| desc_base | output | 64 | Descriptor table address |
| avail_base | output | 64 | Available ring address |
| used_base | output | 64 | Used ring address |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 64 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Eight bytes, little-endian |
| seg_valid | output | 1 | Segment record valid |
| seg_in | output | 1 | 1 = device-writable list |
| seg_pos | output | CNT_W | Position within its list |
| seg_addr | output | 64 | Buffer address |
| seg_len | output | 32 | Buffer length |
| done_valid | output | 1 | Command finished |
| done_empty | output | 1 | Queue was empty |
| done_err | output | 1 | Chain exceeded MAX_SEGS |
| done_head | output | 16 | Head descriptor index |
| done_n_in | output | CNT_W | Writable segment count |
| done_n_out | output | CNT_W | Readable segment count |

## Verification
The bench runs a fetch in peek mode and then in consume mode on the same entry. A walker that advanced the index in peek mode would report a different head on the second fetch. The chains use ring slots and next fields larger than the queue size, and a design that did not reduce them modulo the size would read outside the table. Other cases are a self-linked descriptor, which a walker without a segment limit would follow forever, and commands given on an empty ring, which a faulty design would answer with reads or an index step. A command strobe held high while the walker is busy would, in a design that took it, show up as a second completion.

// File: rtl/vqw_pkg.sv
package vqw_pkg;
    typedef enum logic [1:0] {
        WS_IDLE,
        WS_HEAD,
        WS_LO,
        WS_HI
    } walk_state_e;

    localparam int unsigned DESC_SHIFT      = 4;  // 16-byte descriptors
    localparam int unsigned AVAIL_HDR_BYTES = 4;  // flags + index ahead of the ring
    localparam int unsigned FLAG_CHAIN_BIT  = 0;
    localparam int unsigned FLAG_DEVWR_BIT  = 1;
    localparam int unsigned HI_FLAGS_LSB    = 32;
    localparam int unsigned HI_NEXT_LSB     = 48;
endpackage

// File: rtl/vqw_ring_addr.sv
module vqw_ring_addr
    import vqw_pkg::*;
#(
    parameter int unsigned PFN_W      = 32,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic [PFN_W-1:0] pfn,
    input  logic [3:0]       qlog2,
    output logic [63:0]      desc_base,
    output logic [63:0]      avail_base,
    output logic [63:0]      used_base
);
    localparam logic [63:0] PAGE_MASK = (64'd1 << PAGE_SHIFT) - 64'd1;

    logic [63:0] qsize;
    logic [63:0] avail_end;

    always_comb begin
        qsize      = 64'd1 << qlog2;
        desc_base  = 64'(pfn) << PAGE_SHIFT;
        avail_base = desc_base + (qsize << DESC_SHIFT);
        avail_end  = avail_base + 64'(AVAIL_HDR_BYTES) + (qsize << 1);
        used_base  = (avail_end + PAGE_MASK) & ~PAGE_MASK;
    end
endmodule

// File: rtl/vqw_seg_sort.sv
module vqw_seg_sort #(
    parameter int unsigned MAX_SEGS = 8,
    localparam int unsigned CNT_W   = $clog2(MAX_SEGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             emit,
    input  logic             emit_in,
    input  logic [63:0]      emit_addr,
    input  logic [31:0]      emit_len,
    output logic             seg_valid,
    output logic             seg_in,
    output logic [CNT_W-1:0] seg_pos,
    output logic [63:0]      seg_addr,
    output logic [31:0]      seg_len,
    output logic [CNT_W-1:0] n_in,
    output logic [CNT_W-1:0] n_out
);
    typedef struct packed {
        logic             valid;
        logic             is_in;
        logic [CNT_W-1:0] pos;
        logic [63:0]      addr;
        logic [31:0]      len;
        logic [CNT_W-1:0] n_in;
        logic [CNT_W-1:0] n_out;
    } sort_t;

    sort_t sort_d, sort_q;

    always_comb begin
        sort_d       = sort_q;
        sort_d.valid = 1'b0;
        if (clr) begin
            sort_d.n_in  = '0;
            sort_d.n_out = '0;
        end
        if (emit) begin
            sort_d.valid = 1'b1;
            sort_d.is_in = emit_in;
            sort_d.addr  = emit_addr;
            sort_d.len   = emit_len;
            if (emit_in) begin
                sort_d.pos  = sort_q.n_in;
                sort_d.n_in = sort_q.n_in + CNT_W'(1);
            end else begin
                sort_d.pos   = sort_q.n_out;
                sort_d.n_out = sort_q.n_out + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sort_q <= '0;
        else        sort_q <= sort_d;
    end

    assign seg_valid = sort_q.valid;
    assign seg_in    = sort_q.is_in;
    assign seg_pos   = sort_q.pos;
    assign seg_addr  = sort_q.addr;
    assign seg_len   = sort_q.len;
    assign n_in      = sort_q.n_in;
    assign n_out     = sort_q.n_out;

    AST_SEG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, sort_q.n_in} + {1'b0, sort_q.n_out}) <= (CNT_W+1)'(MAX_SEGS)); // R9
endmodule

// File: rtl/vq_chain_walker.sv
module vq_chain_walker
    import vqw_pkg::*;
#(
    parameter int unsigned PFN_W      = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned MAX_SEGS   = 8,
    localparam int unsigned CNT_W     = $clog2(MAX_SEGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PFN_W-1:0] cfg_pfn,
    input  logic [3:0]       cfg_qlog2,
    input  logic [15:0]      drv_avail_idx,
    input  logic             cmd_valid,
    input  logic             cmd_skip,
    input  logic             cmd_remove,
    output logic             cmd_ready,
    output logic [15:0]      next_avail,
    output logic [63:0]      desc_base,
    output logic [63:0]      avail_base,
    output logic [63:0]      used_base,
    output logic             mem_req,
    output logic [63:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [63:0]      mem_rdata,
    output logic             seg_valid,
    output logic             seg_in,
    output logic [CNT_W-1:0] seg_pos,
    output logic [63:0]      seg_addr,
    output logic [31:0]      seg_len,
    output logic             done_valid,
    output logic             done_empty,
    output logic             done_err,
    output logic [15:0]      done_head,
    output logic [CNT_W-1:0] done_n_in,
    output logic [CNT_W-1:0] done_n_out
);
    localparam logic [CNT_W:0] SEG_LIM = (CNT_W+1)'(MAX_SEGS);

    typedef struct packed {
        walk_state_e st;
        logic [15:0] na;
        logic        rem;
        logic [15:0] head;
        logic [63:0] dptr;
        logic [63:0] saddr;
        logic        req;
        logic [63:0] raddr;
        logic        done;
        logic        dempty;
        logic        derr;
    } walk_t;

    walk_t walk_d, walk_q;

    logic [15:0]    qmask;
    logic           ring_empty;
    logic           sort_clr;
    logic           sort_emit;
    logic [CNT_W:0] seg_total;
    logic [15:0]    nxt_idx;

    vqw_ring_addr #(
        .PFN_W      (PFN_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_addr (
        .pfn        (cfg_pfn),
        .qlog2      (cfg_qlog2),
        .desc_base  (desc_base),
        .avail_base (avail_base),
        .used_base  (used_base)
    );

    vqw_seg_sort #(
        .MAX_SEGS (MAX_SEGS)
    ) u_sort (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sort_clr),
        .emit      (sort_emit),
        .emit_in   (mem_rdata[HI_FLAGS_LSB + FLAG_DEVWR_BIT]),
        .emit_addr (walk_q.saddr),
        .emit_len  (mem_rdata[31:0]),
        .seg_valid (seg_valid),
        .seg_in    (seg_in),
        .seg_pos   (seg_pos),
        .seg_addr  (seg_addr),
        .seg_len   (seg_len),
        .n_in      (done_n_in),
        .n_out     (done_n_out)
    );

    always_comb begin
        qmask      = 16'((32'd1 << cfg_qlog2) - 32'd1);
        ring_empty = (walk_q.na == drv_avail_idx);
        seg_total  = {1'b0, done_n_in} + {1'b0, done_n_out};
        nxt_idx    = mem_rdata[HI_NEXT_LSB +: 16];

        walk_d        = walk_q;
        walk_d.req    = 1'b0;
        walk_d.done   = 1'b0;
        walk_d.dempty = 1'b0;
        walk_d.derr   = 1'b0;
        sort_clr      = 1'b0;
        sort_emit     = 1'b0;

        unique case (walk_q.st)
            WS_IDLE: begin
                if (cmd_valid) begin
                    if (ring_empty) begin
                        walk_d.done   = 1'b1;
                        walk_d.dempty = 1'b1;
                    end else if (cmd_skip) begin
                        walk_d.na   = walk_q.na + 16'd1;
                        walk_d.done = 1'b1;
                    end else begin
                        sort_clr     = 1'b1;
                        walk_d.rem   = cmd_remove;
                        walk_d.req   = 1'b1;
                        walk_d.raddr = avail_base + 64'(AVAIL_HDR_BYTES)
                                     + {47'b0, walk_q.na & qmask, 1'b0};
                        walk_d.st    = WS_HEAD;
                    end
                end
            end
            WS_HEAD: begin
                if (mem_rvalid) begin
                    walk_d.head = mem_rdata[15:0];
                    if (walk_q.rem) walk_d.na = walk_q.na + 16'd1;
                    walk_d.dptr  = desc_base + {44'b0, mem_rdata[15:0] & qmask, 4'b0};
                    walk_d.req   = 1'b1;
                    walk_d.raddr = walk_d.dptr;
                    walk_d.st    = WS_LO;
                end
            end
            WS_LO: begin
                if (mem_rvalid) begin
                    walk_d.saddr = mem_rdata;
                    walk_d.req   = 1'b1;
                    walk_d.raddr = walk_q.dptr + 64'd8;
                    walk_d.st    = WS_HI;
                end
            end
            WS_HI: begin
                if (mem_rvalid) begin
                    sort_emit = 1'b1;
                    if (mem_rdata[HI_FLAGS_LSB + FLAG_CHAIN_BIT]) begin
                        if (seg_total + (CNT_W+1)'(1) == SEG_LIM) begin
                            walk_d.done = 1'b1;
                            walk_d.derr = 1'b1;
                            walk_d.st   = WS_IDLE;
                        end else begin
                            walk_d.dptr  = desc_base + {44'b0, nxt_idx & qmask, 4'b0};
                            walk_d.req   = 1'b1;
                            walk_d.raddr = walk_d.dptr;
                            walk_d.st    = WS_LO;
                        end
                    end else begin
                        walk_d.done = 1'b1;
                        walk_d.st   = WS_IDLE;
                    end
                end
            end
            default: walk_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q    <= '0;
            walk_q.st <= WS_IDLE;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign cmd_ready  = (walk_q.st == WS_IDLE);
    assign next_avail = walk_q.na;
    assign mem_req    = walk_q.req;
    assign mem_addr   = walk_q.raddr;
    assign done_valid = walk_q.done;
    assign done_empty = walk_q.dempty;
    assign done_err   = walk_q.derr;
    assign done_head  = walk_q.head;

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (next_avail != $past(next_avail)) |-> (next_avail == $past(next_avail) + 16'd1)); // R5
    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_empty) |-> (next_avail == $past(next_avail) && !seg_valid)); // R3
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_req); // R11
    AST_ERR_IS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> (done_valid && !done_empty)); // R9
    AST_USED_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (used_base[PAGE_SHIFT-1:0] == '0) && (used_base > avail_base)); // R2
endmodule

// File: tb/vq_chain_walker_test.sv
`timescale 1ns/1ps
module vq_chain_walker_test;
    localparam int MAXS = 8;
    localparam int CW   = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic [31:0] cfg_pfn;
    logic [3:0]  cfg_qlog2;
    logic [15:0] drv_avail_idx;
    logic cmd_valid, cmd_skip, cmd_remove, cmd_ready;
    logic [15:0] next_avail;
    logic [63:0] desc_base, avail_base, used_base;
    logic mem_req, mem_rvalid;
    logic [63:0] mem_addr, mem_rdata;
    logic seg_valid, seg_in;
    logic [CW-1:0] seg_pos;
    logic [63:0] seg_addr;
    logic [31:0] seg_len;
    logic done_valid, done_empty, done_err;
    logic [15:0] done_head;
    logic [CW-1:0] done_n_in, done_n_out;

    always #4 clk = ~clk;

    vq_chain_walker uut (
        .clk(clk), .rst_n(rst_n), .cfg_pfn(cfg_pfn), .cfg_qlog2(cfg_qlog2),
        .drv_avail_idx(drv_avail_idx), .cmd_valid(cmd_valid), .cmd_skip(cmd_skip),
        .cmd_remove(cmd_remove), .cmd_ready(cmd_ready), .next_avail(next_avail),
        .desc_base(desc_base), .avail_base(avail_base), .used_base(used_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .seg_valid(seg_valid), .seg_in(seg_in),
        .seg_pos(seg_pos), .seg_addr(seg_addr), .seg_len(seg_len),
        .done_valid(done_valid), .done_empty(done_empty), .done_err(done_err),
        .done_head(done_head), .done_n_in(done_n_in), .done_n_out(done_n_out)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [0:8191];

    // bench model of the queue contents (size 4)
    logic [63:0] t_addr [0:3];
    logic [31:0] t_len  [0:3];
    logic [15:0] t_fl   [0:3];
    logic [15:0] t_nx   [0:3];
    logic [15:0] av     [0:3];
    logic [15:0] exp_na;

    // observed per command
    logic [63:0] rd_addr [0:63];
    int rd_n;
    logic        a_in   [0:31];
    logic [CW-1:0] a_pos [0:31];
    logic [63:0] a_addr [0:31];
    logic [31:0] a_len  [0:31];
    int a_n, n_done;
    logic r_empty, r_err;
    logic [15:0] r_head;
    logic [CW-1:0] r_nin, r_nout;

    localparam longint DBASE = 4096;
    localparam longint ABASE = 4096 + 64;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] rd64(input logic [63:0] a);
        logic [63:0] v;
        for (int b = 0; b < 8; b++) v[8*b +: 8] = mem[13'(a + 64'(b))];
        return v;
    endfunction

    task automatic wr_bytes(input longint a, input logic [63:0] v, input int nb);
        for (int b = 0; b < nb; b++) mem[13'(a + b)] = v[8*b +: 8];
    endtask

    task automatic set_desc(input int i, input logic [63:0] ad, input logic [31:0] ln,
                            input logic [15:0] fl, input logic [15:0] nx);
        t_addr[i] = ad; t_len[i] = ln; t_fl[i] = fl; t_nx[i] = nx;
        wr_bytes(DBASE + 16*i, ad, 8);
        wr_bytes(DBASE + 16*i + 8, {nx, fl, ln}, 8);
    endtask

    task automatic set_avail(input int slot, input logic [15:0] v);
        av[slot] = v;
        wr_bytes(ABASE + 4 + 2*slot, {48'b0, v}, 2);
    endtask

    // memory responder: latency cycles 0,1,2 in turn
    initial begin
        int lat = 0;
        logic [63:0] a;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        rd_n = 0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req === 1'b1) begin
                a = mem_addr;
                if (rd_n < 64) rd_addr[rd_n] = a;
                rd_n++;
                repeat (lat) @(negedge clk);
                mem_rdata  = rd64(a);
                mem_rvalid = 1'b1;
                lat = (lat + 1) % 3;
            end
        end
    end

    task automatic run_cmd(input logic skip, input logic rem, input int hold);
        int c;
        rd_n = 0; a_n = 0; n_done = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_skip = skip; cmd_remove = rem;
        c = 0;
        while (c < 400 && n_done == 0) begin
            @(negedge clk);
            if (c + 1 >= hold) cmd_valid = 1'b0;
            if (seg_valid && a_n < 32) begin
                a_in[a_n] = seg_in; a_pos[a_n] = seg_pos;
                a_addr[a_n] = seg_addr; a_len[a_n] = seg_len; a_n++;
            end
            if (done_valid) begin
                n_done++;
                r_empty = done_empty; r_err = done_err; r_head = done_head;
                r_nin = done_n_in; r_nout = done_n_out;
            end
            c++;
        end
        cmd_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done_valid) n_done++;
            if (seg_valid) a_n++;
        end
    endtask

    // run one command and compare against the bench's own walk of the model
    task automatic do_op(input logic skip, input logic rem, input int hold);
        logic is_empty;
        is_empty = (exp_na == drv_avail_idx);
        run_cmd(skip, rem, hold);
        chk("R11 one completion", 64'(n_done), 64'd1);
        if (is_empty) begin
            chk("R3 empty flag", 64'(r_empty), 64'd1);
            chk("R3 no reads", 64'(rd_n), 64'd0);
            chk("R3 no segments", 64'(a_n), 64'd0);
            chk("R3 index kept", 64'(next_avail), 64'(exp_na));
        end else if (skip) begin
            exp_na = exp_na + 16'd1;
            chk("R6 not empty", 64'(r_empty), 64'd0);
            chk("R6 no reads", 64'(rd_n), 64'd0);
            chk("R6 no segments", 64'(a_n), 64'd0);
            chk("R6 index step", 64'(next_avail), 64'(exp_na));
        end else begin
            logic [15:0] head;
            int idx, ns, ni, no;
            logic err;
            head = av[exp_na & 16'd3];
            chk("R4 head read addr", rd_addr[0], 64'(ABASE + 4 + 2*(exp_na & 16'd3)));
            idx = int'(head & 16'd3); ns = 0; ni = 0; no = 0; err = 1'b0;
            for (int k = 0; k < MAXS; k++) begin
                logic w;
                w = t_fl[idx][1];
                chk("R4 desc lo addr", rd_addr[1 + 2*k], 64'(DBASE + 16*idx));
                chk("R4 desc hi addr", rd_addr[2 + 2*k], 64'(DBASE + 16*idx + 8));
                chk("R7 list", 64'(a_in[k]), 64'(w));
                chk("R7 position", 64'(a_pos[k]), w ? 64'(ni) : 64'(no));
                chk("R7 seg addr", a_addr[k], t_addr[idx]);
                chk("R7 seg len", 64'(a_len[k]), 64'(t_len[idx]));
                if (w) ni++; else no++;
                ns++;
                if (!t_fl[idx][0]) break;
                if (ns == MAXS) begin err = 1'b1; break; end
                idx = int'(t_nx[idx] & 16'd3);
            end
            if (rem) exp_na = exp_na + 16'd1;
            chk("R8 segment count", 64'(a_n), 64'(ns));
            chk("R9 error flag", 64'(r_err), 64'(err));
            chk("R9 read count", 64'(rd_n), 64'(1 + 2*ns));
            chk("R10 head", 64'(r_head), 64'(head));
            chk("R10 in count", 64'(r_nin), 64'(ni));
            chk("R10 out count", 64'(r_nout), 64'(no));
            chk("R5 index", 64'(next_avail), 64'(exp_na));
            chk("R3 not empty", 64'(r_empty), 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_skip = 1'b0; cmd_remove = 1'b0;
        cfg_pfn = 32'd0; cfg_qlog2 = 4'd0; drv_avail_idx = 16'd0; exp_na = 16'd0;
        for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R12 ready", 64'(cmd_ready), 64'd1);
        chk("R12 index", 64'(next_avail), 64'd0);
        chk("R12 req", 64'(mem_req), 64'd0);
        chk("R12 seg", 64'(seg_valid), 64'd0);
        chk("R12 done", 64'(done_valid), 64'd0);
        rst_n = 1'b1;

        // ring address sweep
        for (int p = 0; p < 6; p++) begin
            for (int q = 0; q < 16; q++) begin
                longint d, a, u, n;
                cfg_pfn = 32'(p); cfg_qlog2 = 4'(q);
                #1;
                n = longint'(1) << q;
                d = longint'(p) * 4096;
                a = d + 16*n;
                u = ((a + 4 + 2*n + 4095) / 4096) * 4096;
                chk("R1 desc base", desc_base, 64'(d));
                chk("R1 avail base", avail_base, 64'(a));
                chk("R2 used base", used_base, 64'(u));
            end
        end
        @(negedge clk);
        cfg_pfn = 32'd1; cfg_qlog2 = 4'd2;

        // empty ring: fetch and skip
        do_op(1'b0, 1'b1, 1);
        do_op(1'b1, 1'b0, 1);

        // chain 2 -> 3 -> (4 mod 4 = 0); single descriptor 1
        set_desc(2, 64'h0000_1111_0000_2000, 32'h100, 16'h0001, 16'd3);
        set_desc(3, 64'h0000_2222_0000_3000, 32'h40,  16'h0003, 16'd4);
        set_desc(0, 64'h0000_3333_0000_4000, 32'h80,  16'h0002, 16'd9);
        set_desc(1, 64'h0000_4444_0000_5000, 32'h20,  16'h0000, 16'd0);
        set_avail(0, 16'd2);
        set_avail(1, 16'd6);
        set_avail(2, 16'd1);
        set_avail(3, 16'd1);
        drv_avail_idx = 16'd5;

        do_op(1'b0, 1'b0, 1);   // R5 peek
        do_op(1'b0, 1'b1, 1);   // R5 consume, same entry
        do_op(1'b0, 1'b1, 3);   // R11 strobe held while busy; head 6 wraps to desc 2
        do_op(1'b1, 1'b0, 1);   // R6 skip
        do_op(1'b0, 1'b1, 1);   // single out segment

        // self-linked descriptor: R9 limit
        set_desc(1, 64'h0000_5555_0000_6000, 32'h10, 16'h0003, 16'd5);
        set_avail(0, 16'd1);
        do_op(1'b0, 1'b1, 1);

        // ring now drained
        do_op(1'b0, 1'b1, 1);
        do_op(1'b1, 1'b0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule